// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block is the write-permission authority of a serial flash memory core. It holds the write-enable latch, the busy flag, a two-bit block-protect level and a protect-pin-enable bit. It also judges every write-class command: status write, page program, sector erase, block erase and chip erase. A command front-end hands it decoded command strobes with an address and a data byte while chip enable is low. When chip enable rises, the controller issues exactly one grant or deny pulse for the pending write-class command. A grant starts the self-timed write cycle. The cycle timer later returns a done pulse, which ends the cycle.

The decision takes into account:
- the write-enable latch;
- the level of the active-low write-protect pin, and whether that pin has been armed by the protect-pin-enable bit;
- the protection level;
- the quarter of the array that the address falls in.

On a grant, the controller also reports which array quarters the operation may touch. It supplies the status byte for status reads. The non-volatile status bits are modelled as ordinary registers. The array contents are handled elsewhere.

Top module: `wp_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00. A write-class command (op codes 3 to 7) is denied unless a write-enable command (op 0) was accepted earlier and the latch is still set.
- R2: A write-disable command (op 1) clears the write-enable latch whatever the level of `wp_n` and the value of the enable bit.
- R3: The pin protection is armed only when `wp_n` is 0 and the protect-pin-enable bit is 1. With that bit at 0, a status write (op 3) is granted even when `wp_n` is low.
- R4: While the pin protection is armed, a status write is denied.
- R5: The protection level in status bits 3:2 selects the protected quarters: 00 none, 01 quarter 3, 10 quarters 3 and 2, 11 all. A chip erase (op 7) is granted with `grant_mask` set to the unprotected quarters, where bit i means quarter i. It is denied when no quarter is left unprotected.
- R6: A page program (op 4), sector erase (op 5) or block erase (op 6) whose address lies in a protected quarter is denied. When granted, `grant_mask` is one-hot on the quarter given by the two top address bits.
- R7: Status bit 0 is 1 from the grant until the done pulse. While it is 1, every command except status read (op 2) is ignored: it produces no grant or deny pulse and leaves the latch unchanged.
- R8: A done pulse during a cycle clears both busy and the write-enable latch. A status write's new bits (data bits 7, 3 and 2) take effect at that done pulse.
- R9: A status write is denied if `wp_n` goes low while the enable bit is 1 and chip enable is still low. Once the status write has been granted, `wp_n` has no effect on it.
- R10: Status layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level, bit 7 protect-pin-enable, and bits 6:4 always 0.
- R11: A denied command leaves the write-enable latch unchanged and does not set busy.
- R12: A pending write-class command yields exactly one of `grant` and `deny` as a one-cycle pulse. The pulse comes in the cycle after the first clock edge that samples `cs_n` high. Only the first write-class command within one selection is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip enable, active low |
| wp_n | input | 1 | Write-protect pin level, active low |
| cmd_stb | input | 1 | One-cycle strobe of a decoded command |
| cmd_op | input | 3 | Op: 0 wr-enable, 1 wr-disable, 2 status read, 3 status write, 4 program, 5 sector erase, 6 block erase, 7 chip erase |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Status-write data byte |
| cyc_done | input | 1 | Write-cycle timer completion pulse |
| grant | output | 1 | Write cycle starts (pulse) |
| deny | output | 1 | Write command rejected (pulse) |
| grant_op | output | 3 | Op of the granted command |
| grant_addr | output | ADDR_W | Address of the granted command |
| grant_mask | output | 4 | Array quarters the granted operation may touch |
| busy | output | 1 | Write cycle in progress |
| status | output | 8 | Status byte |

## Verification
Two events can land on the same decision edge. One is the falling edge of the protect pin. The other is chip enable rising on a pending status write, with the enable bit armed. The bench pulls `wp_n` low and back high again while chip enable is still low. It then expects a deny, while the write-enable latch stays set in the status byte. A second case pulls the pin low after the grant. The bench then expects the new status bits to appear at the done pulse. Commands strobed inside a busy window are judged by the absence of any grant or deny pulse and by an unchanged status byte.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  localparam int NQ = 4;

  localparam int ST_BUSY  = 0;
  localparam int ST_WEL   = 1;
  localparam int ST_BP_LO = 2;
  localparam int ST_WPEN  = 7;

  typedef enum logic [2:0] {
    OP_WREN   = 3'd0,
    OP_WRDI   = 3'd1,
    OP_RDSR   = 3'd2,
    OP_WRSR   = 3'd3,
    OP_PROG   = 3'd4,
    OP_SERASE = 3'd5,
    OP_BERASE = 3'd6,
    OP_CERASE = 3'd7
  } wpc_op_e;

  function automatic logic is_write_cls(input wpc_op_e op);
    return (op == OP_WRSR) || op[2];
  endfunction

  function automatic logic [NQ-1:0] prot_mask(input logic [1:0] lvl);
    logic [NQ-1:0] m;
    case (lvl)
      2'b00:   m = 4'b0000;
      2'b01:   m = 4'b1000;
      2'b10:   m = 4'b1100;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  function automatic logic [7:0] pack_status(input logic bsy, input logic wel,
                                             input logic [1:0] lvl, input logic pen);
    logic [7:0] s;
    s = 8'h00;
    s[ST_BUSY] = bsy;
    s[ST_WEL] = wel;
    s[ST_BP_LO +: 2] = lvl;
    s[ST_WPEN] = pen;
    return s;
  endfunction

endpackage

// File: rtl/wpc_track.sv
module wpc_track
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              pen,
  input  logic              busy,
  input  logic              cmd_stb,
  input  wpc_op_e           cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [2:0]        cmd_sbits,
  output logic              sel_end,
  output logic              pend,
  output logic              abort,
  output wpc_op_e           pend_op,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [2:0]        pend_sbits,
  output logic              wren_acc,
  output logic              wrdi_acc
);

  logic cs_q;
  logic live;
  logic take;
  logic pin_trip;

  assign sel_end  = !cs_q && cs_n;
  assign live     = cmd_stb && !cs_n && !busy;
  assign take     = live && is_write_cls(cmd_op) && !pend;
  assign wren_acc = live && (cmd_op == OP_WREN);
  assign wrdi_acc = live && (cmd_op == OP_WRDI);
  assign pin_trip = pend && (pend_op == OP_WRSR) && !cs_n && !wp_n && pen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
    end else begin
      cs_q <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      abort      <= 1'b0;
      pend_op    <= OP_WREN;
      pend_addr  <= '0;
      pend_sbits <= '0;
    end else if (take) begin
      pend       <= 1'b1;
      abort      <= 1'b0;
      pend_op    <= cmd_op;
      pend_addr  <= cmd_addr;
      pend_sbits <= cmd_sbits;
    end else if (sel_end) begin
      pend  <= 1'b0;
      abort <= 1'b0;
    end else if (pin_trip) begin
      abort <= 1'b1;
    end
  end

endmodule

// File: rtl/wpc_gate.sv
module wpc_gate
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  wpc_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              abort,
  input  logic              wel,
  input  logic [1:0]        lvl,
  input  logic              pen,
  input  logic              wp_n,
  output logic              hw_lock,
  output logic              allow,
  output logic [NQ-1:0]     mask
);

  localparam int QW = $clog2(NQ);

  logic [NQ-1:0] locked;
  logic [NQ-1:0] hit;
  logic [QW-1:0] tq;
  logic          ok;

  assign hw_lock = !wp_n && pen;
  assign locked  = prot_mask(lvl);
  assign tq      = addr[ADDR_W-1 -: QW];

  for (genvar q = 0; q < NQ; q++) begin : g_quarter
    assign hit[q] = (tq == QW'(q));
  end

  always_comb begin
    ok   = 1'b0;
    mask = '0;
    case (op)
      OP_WRSR: begin
        ok = !hw_lock && !abort;
      end
      OP_CERASE: begin
        mask = ~locked;
        ok   = |mask;
      end
      OP_PROG, OP_SERASE, OP_BERASE: begin
        mask = hit;
        ok   = !(|(hit & locked));
      end
      default: begin
        ok = 1'b0;
      end
    endcase
  end

  assign allow = wel && ok;

endmodule

// File: rtl/wpc_regs.sv
module wpc_regs
  import wpc_pkg::*;
#(
  parameter logic [1:0] LVL_RST = 2'b00,
  parameter logic       PEN_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wren_acc,
  input  logic       wrdi_acc,
  input  logic       start,
  input  wpc_op_e    start_op,
  input  logic [2:0] start_sbits,
  input  logic       done,
  output logic       busy,
  output logic       wel,
  output logic [1:0] lvl,
  output logic       pen,
  output logic       finish
);

  logic       cyc_sr;
  logic [2:0] stage;

  assign finish = done && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wel    <= 1'b0;
      cyc_sr <= 1'b0;
      stage  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cyc_sr <= (start_op == OP_WRSR);
      stage  <= start_sbits;
    end else if (finish) begin
      busy   <= 1'b0;
      wel    <= 1'b0;
      cyc_sr <= 1'b0;
    end else if (wrdi_acc) begin
      wel <= 1'b0;
    end else if (wren_acc) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= LVL_RST;
      pen <= PEN_RST;
    end else if (finish && cyc_sr) begin
      pen <= stage[2];
      lvl <= stage[1:0];
    end
  end

endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wpc_pkg::*;
#(
  parameter int         ADDR_W  = 17,
  parameter logic [1:0] LVL_RST = 2'b00,
  parameter logic       PEN_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cmd_stb,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              cyc_done,
  output logic              grant,
  output logic              deny,
  output logic [2:0]        grant_op,
  output logic [ADDR_W-1:0] grant_addr,
  output logic [3:0]        grant_mask,
  output logic              busy,
  output logic [7:0]        status
);

  wpc_op_e           op_in;
  wpc_op_e           pend_op;
  logic              sel_end, pend, abort;
  logic [ADDR_W-1:0] pend_addr;
  logic [2:0]        pend_sbits;
  logic              wren_acc, wrdi_acc;
  logic              wel, pen, finish, hw_lock, allow;
  logic [1:0]        lvl;
  logic [NQ-1:0]     mask;
  logic              decide, grant_d, deny_d;
  logic              unused_data_bits;

  assign op_in            = wpc_op_e'(cmd_op);
  assign unused_data_bits = ^{cmd_data[6:4], cmd_data[1:0]};

  wpc_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .pen(pen), .busy(busy),
    .cmd_stb(cmd_stb), .cmd_op(op_in), .cmd_addr(cmd_addr),
    .cmd_sbits({cmd_data[ST_WPEN], cmd_data[ST_BP_LO +: 2]}),
    .sel_end(sel_end), .pend(pend), .abort(abort), .pend_op(pend_op),
    .pend_addr(pend_addr), .pend_sbits(pend_sbits),
    .wren_acc(wren_acc), .wrdi_acc(wrdi_acc)
  );

  wpc_gate #(.ADDR_W(ADDR_W)) u_gate (
    .op(pend_op), .addr(pend_addr), .abort(abort), .wel(wel), .lvl(lvl),
    .pen(pen), .wp_n(wp_n), .hw_lock(hw_lock), .allow(allow), .mask(mask)
  );

  assign decide  = sel_end && pend;
  assign grant_d = decide && allow;
  assign deny_d  = decide && !allow;

  wpc_regs #(.LVL_RST(LVL_RST), .PEN_RST(PEN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wren_acc(wren_acc), .wrdi_acc(wrdi_acc),
    .start(grant_d), .start_op(pend_op), .start_sbits(pend_sbits),
    .done(cyc_done), .busy(busy), .wel(wel), .lvl(lvl), .pen(pen),
    .finish(finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant      <= 1'b0;
      deny       <= 1'b0;
      grant_op   <= '0;
      grant_addr <= '0;
      grant_mask <= '0;
    end else begin
      grant <= grant_d;
      deny  <= deny_d;
      if (grant_d) begin
        grant_op   <= pend_op;
        grant_addr <= pend_addr;
        grant_mask <= mask;
      end
    end
  end

  assign status = pack_status(busy, wel, lvl, pen);

endmodule

// File: rtl/wpc_chk.sv
module wpc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       grant,
  input logic       deny,
  input logic [2:0] grant_op,
  input logic       busy,
  input logic       wel,
  input logic       hw_lock,
  input logic       wrdi_acc,
  input logic       finish,
  input logic [7:0] status
);

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny)); // R12

  AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> busy && !$past(busy)); // R7

  AST_DENY_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> (wel == $past(wel)) && !busy); // R11

  AST_FINISH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy && !wel); // R8

  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi_acc |=> !wel); // R2

  AST_SR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && grant_op == 3'd3) |-> !$past(hw_lock)); // R4

  AST_STATUS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == busy); // R10

endmodule

bind wp_status_ctrl wpc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .deny(deny), .grant_op(grant_op),
  .busy(busy), .wel(wel), .hw_lock(hw_lock), .wrdi_acc(wrdi_acc),
  .finish(finish), .status(status)
);

// File: tb/wp_status_ctrl_tb.sv
module wp_status_ctrl_tb;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          wp_n = 1'b1;
  logic          cmd_stb = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic          cyc_done = 1'b0;
  logic          grant, deny, busy;
  logic [2:0]    grant_op;
  logic [AW-1:0] grant_addr;
  logic [3:0]    grant_mask;
  logic [7:0]    status;

  int checks = 0;
  int fails = 0;

  typedef struct {
    bit       g;
    bit [2:0] op;
    bit [3:0] m;
    string    req;
  } exp_t;

  exp_t expq[$];

  always #2 clk = ~clk;

  wp_status_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_stb(cmd_stb),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cyc_done(cyc_done), .grant(grant), .deny(deny), .grant_op(grant_op),
    .grant_addr(grant_addr), .grant_mask(grant_mask), .busy(busy),
    .status(status)
  );

  function automatic logic [AW-1:0] qaddr(input int q, input int off);
    return AW'(q) << (AW - 2) | AW'(off);
  endfunction

  // monitor: every decision pulse is compared with the next expectation
  always @(negedge clk) begin
    if (rst_n && (grant || deny)) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R12: unexpected pulse grant=%0b deny=%0b, expected none", grant, deny);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (grant !== e.g || (e.g && (grant_op !== e.op || grant_mask !== e.m))) begin
          fails++;
          $display("FAIL %s: grant=%0b op=%0d mask=%b, expected grant=%0b op=%0d mask=%b",
                   e.req, grant, grant_op, grant_mask, e.g, e.op, e.m);
        end
      end
    end
  end

  task automatic expect_pulse(input bit g, input bit [2:0] op, input bit [3:0] m,
                              input string req);
    exp_t e;
    e.g = g; e.op = op; e.m = m; e.req = req;
    expq.push_back(e);
  endtask

  task automatic send(input bit [2:0] op, input logic [AW-1:0] a, input bit [7:0] d);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic sel_open();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic sel_close();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic one(input bit [2:0] op, input logic [AW-1:0] a, input bit [7:0] d);
    sel_open();
    send(op, a, d);
    sel_close();
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_status(input bit [7:0] exp, input string req);
    @(negedge clk);
    checks++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s: status=%02h expected %02h", req, status, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_status(8'h00, "R1");

    // R1 / R11: program without latch
    expect_pulse(0, 0, 0, "R1");
    one(3'd4, qaddr(0, 4), 8'h00);
    check_status(8'h00, "R11");
    one(3'd0, '0, 8'h00);
    check_status(8'h02, "R1");
    one(3'd1, '0, 8'h00);
    check_status(8'h00, "R2");

    // R10 / R7 / R8: status write, junk bits ignored
    one(3'd0, '0, 8'h00);
    expect_pulse(1, 3'd3, 4'b0000, "R12");
    one(3'd3, '0, 8'hF5);
    check_status(8'h03, "R7");
    one(3'd1, '0, 8'h00);       // ignored while busy
    one(3'd4, qaddr(0, 1), 8'h00); // ignored, no pulse expected
    check_status(8'h03, "R7");
    finish_cycle();
    check_status(8'h84, "R8");
    check_status(8'h84, "R10");

    // R6: level 01 protects quarter 3
    one(3'd0, '0, 8'h00);
    expect_pulse(0, 0, 0, "R6");
    one(3'd4, qaddr(3, 5), 8'h00);
    check_status(8'h86, "R11");
    expect_pulse(1, 3'd5, 4'b0100, "R6");
    one(3'd5, qaddr(2, 9), 8'h00);
    finish_cycle();
    check_status(8'h84, "R8");

    // R5: chip erase at level 01
    one(3'd0, '0, 8'h00);
    expect_pulse(1, 3'd7, 4'b0111, "R5");
    one(3'd7, '0, 8'h00);
    finish_cycle();

    // R4 / R2: pin armed
    wp_n = 1'b0;
    one(3'd0, '0, 8'h00);
    expect_pulse(0, 0, 0, "R4");
    one(3'd3, '0, 8'h00);
    check_status(8'h86, "R4");
    one(3'd1, '0, 8'h00);
    check_status(8'h84, "R2");

    // level 10, pin released
    wp_n = 1'b1;
    one(3'd0, '0, 8'h00);
    expect_pulse(1, 3'd3, 4'b0000, "R3");
    one(3'd3, '0, 8'h08);
    finish_cycle();
    check_status(8'h08, "R8");
    one(3'd0, '0, 8'h00);
    expect_pulse(1, 3'd7, 4'b0011, "R5");
    one(3'd7, '0, 8'h00);
    finish_cycle();

    // R3: enable bit 0, pin low has no effect
    wp_n = 1'b0;
    one(3'd0, '0, 8'h00);
    expect_pulse(1, 3'd3, 4'b0000, "R3");
    one(3'd3, '0, 8'h0C);
    finish_cycle();
    check_status(8'h0C, "R3");
    one(3'd0, '0, 8'h00);
    expect_pulse(0, 0, 0, "R5");
    one(3'd7, '0, 8'h00);
    expect_pulse(0, 0, 0, "R6");
    one(3'd6, qaddr(0, 0), 8'h00);
    check_status(8'h0E, "R11");
    expect_pulse(1, 3'd3, 4'b0000, "R3");
    one(3'd3, '0, 8'h80);
    finish_cycle();
    check_status(8'h80, "R8");
    wp_n = 1'b1;

    // R9: pin falls while selected -> cancelled
    one(3'd0, '0, 8'h00);
    expect_pulse(0, 0, 0, "R9");
    sel_open();
    send(3'd3, '0, 8'h00);
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk); wp_n = 1'b1;
    sel_close();
    check_status(8'h82, "R9");

    // R9: pin falls after grant -> write still lands
    expect_pulse(1, 3'd3, 4'b0000, "R9");
    one(3'd3, '0, 8'h00);
    wp_n = 1'b0;
    finish_cycle();
    check_status(8'h00, "R9");
    wp_n = 1'b1;

    // R12: only the first write command in a selection is kept
    one(3'd0, '0, 8'h00);
    expect_pulse(1, 3'd4, 4'b0010, "R12");
    sel_open();
    send(3'd4, qaddr(1, 3), 8'h00);
    send(3'd7, '0, 8'h00);
    sel_close();
    finish_cycle();

    // R5: level 00 chip erase covers all quarters
    one(3'd0, '0, 8'h00);
    expect_pulse(1, 3'd7, 4'b1111, "R5");
    one(3'd7, '0, 8'h00);
    finish_cycle();
    check_status(8'h00, "R8");

    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R12: %0d decisions missing, expected 0", expq.size());
    end
    report();
  end

endmodule